// File: doc/BRIEF.md
# Pseudo-Random Sequence Generator with Cycle-Length Meter

This block produces a 16-bit pseudo-random sequence from a right-shifting Fibonacci linear-feedback shift register. On every enabled step the register moves one place toward bit 0. A new bit, formed by the parity of a fixed set of tap positions, enters at the top.

Next to the register sits a step counter. The counter measures how many steps the sequence needs to come back to its seed. The seed is the default value after reset, or any value loaded through the seed port. When the register reaches the seed again, a flag pulses for one cycle and the counter starts over. The comparison is made only after a step, never on the seed value the register was just given. A seed of zero would lock the register forever, so it is swapped for the default seed. With the built-in taps the sequence is maximal, so every measured cycle is 65535 steps long.

Top module: `prbs_cycle_meter`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the next clock edge sets the state to 0xACE1, the step count to 0 and the wrap flag to 0. The stored seed also becomes 0xACE1.
- R2: On a step, the new state is the old state shifted right by one place. Bit 15 of the new state is the XOR of old bits 0, 2, 3 and 5.
- R3: On a cycle with neither step nor load, the state and the step count keep their values, and the wrap flag is 0.
- R4: On a step that does not bring the state back to the stored seed, the step count rises by exactly one and the wrap flag is 0.
- R5: A load replaces the state and the stored seed with the seed input, clears the step count and the wrap flag, and wins over a step requested in the same cycle.
- R6: A load with a seed input of 0 acts exactly like a load of 0xACE1, so the state is never zero.
- R7: A step that makes the state equal the stored seed sets the wrap flag for that one cycle and returns the step count to 0. Right after a reset or a load, the state equals the seed but no wrap is flagged.
- R8: Starting from the default seed, or from any loaded nonzero seed, exactly 65535 steps separate a reset or load and the first wrap, and each wrap from the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Advance the register and the counter by one step |
| load_i | input | 1 | Take seed_i as the new state and seed |
| seed_i | input | 16 | Seed value for a load; 0 selects the default seed |
| state_o | output | 16 | Current register state |
| steps_o | output | 17 | Steps taken since the last reset, load or wrap |
| wrap_o | output | 1 | One-cycle pulse when a step returns the state to the seed |

## Verification
Two functions can land on the same edge. A load can meet a step, and the step that would wrap the sequence can be the last one before a load. The bench raises the load and step inputs together, both with a normal seed and with a zero seed. It then checks that the state holds the guarded seed, that the count is zero, and that no wrap is flagged. Full periods are run from the default seed and from a loaded seed of 0x0001. The wrap pulses are judged by the number of applied steps the bench counts between them at the ports.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    // Default register width and tap mask (bits 0, 2, 3, 5 feed the new MSB).
    localparam int unsigned PRBS_W_DFLT    = 16;
    localparam logic [15:0] PRBS_TAPS_DFLT = 16'h002D;
    localparam logic [15:0] PRBS_SEED_DFLT = 16'hACE1;

    // Action taken by the register on one clock edge, in priority order.
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2,
        ACT_RST  = 2'd3
    } prbs_act_e;

endpackage

// File: rtl/prbs_tap_xor.sv
module prbs_tap_xor #(
    parameter int unsigned WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS = 16'h002D
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] nxt_o,
    output logic             fb_o
);
    logic [WIDTH-1:0] masked;

    // One AND term per position; positions outside the tap mask drop out.
    for (genvar g = 0; g < WIDTH; g++) begin : g_tap
        if (TAPS[g]) begin : g_on
            assign masked[g] = cur_i[g];
        end else begin : g_off
            assign masked[g] = 1'b0;
        end
    end

    assign fb_o  = ^masked;
    assign nxt_o = {fb_o, cur_i[WIDTH-1:1]};
endmodule

// File: rtl/prbs_seed_guard.sv
module prbs_seed_guard #(
    parameter int unsigned WIDTH = 16,
    parameter logic [WIDTH-1:0] FALLBACK = 16'hACE1
) (
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] safe_o
);
    logic is_zero;

    assign is_zero = (raw_i == '0);
    assign safe_o  = is_zero ? FALLBACK : raw_i;
endmodule

// File: rtl/prbs_action_sel.sv
module prbs_action_sel
    import prbs_pkg::*;
(
    input  logic      rst_i,
    input  logic      load_i,
    input  logic      step_i,
    output prbs_act_e act_o
);
    always_comb begin
        if (rst_i)       act_o = ACT_RST;
        else if (load_i) act_o = ACT_LOAD;
        else if (step_i) act_o = ACT_STEP;
        else             act_o = ACT_IDLE;
    end
endmodule

// File: rtl/prbs_cycle_meter.sv
module prbs_cycle_meter
    import prbs_pkg::*;
#(
    parameter int unsigned WIDTH = PRBS_W_DFLT,
    parameter logic [WIDTH-1:0] TAPS = PRBS_TAPS_DFLT,
    parameter logic [WIDTH-1:0] SEED_DEFAULT = PRBS_SEED_DFLT,
    localparam int unsigned CNT_W = WIDTH + 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             step_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] state_o,
    output logic [CNT_W-1:0] steps_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [WIDTH-1:0] state;
        logic [WIDTH-1:0] seed;
        logic [CNT_W-1:0] steps;
        logic             wrap;
    } meter_t;

    meter_t           r_d, r_q;
    prbs_act_e        act;
    logic [WIDTH-1:0] shifted;
    logic             fb_bit;
    logic [WIDTH-1:0] seed_safe;

    prbs_action_sel u_act (
        .rst_i  (rst_i),
        .load_i (load_i),
        .step_i (step_i),
        .act_o  (act)
    );

    prbs_tap_xor #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
        .cur_i (r_q.state),
        .nxt_o (shifted),
        .fb_o  (fb_bit)
    );

    prbs_seed_guard #(.WIDTH(WIDTH), .FALLBACK(SEED_DEFAULT)) u_guard (
        .raw_i  (seed_i),
        .safe_o (seed_safe)
    );

    // Next-value process.
    always_comb begin
        r_d      = r_q;
        r_d.wrap = 1'b0;
        unique case (act)
            ACT_RST: begin
                r_d.state = SEED_DEFAULT;
                r_d.seed  = SEED_DEFAULT;
                r_d.steps = '0;
            end
            ACT_LOAD: begin
                r_d.state = seed_safe;
                r_d.seed  = seed_safe;
                r_d.steps = '0;
            end
            ACT_STEP: begin
                r_d.state = shifted;
                // Compare only after moving: do-while order.
                if (shifted == r_q.seed) begin
                    r_d.wrap  = 1'b1;
                    r_d.steps = '0;
                end else begin
                    r_d.steps = r_q.steps + 1'b1;
                end
            end
            default: begin
                r_d.state = r_q.state;
            end
        endcase
    end

    // Register process.
    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign state_o = r_q.state;
    assign steps_o = r_q.steps;
    assign wrap_o  = r_q.wrap;

    logic unused_fb;
    assign unused_fb = fb_bit;
endmodule

// File: rtl/prbs_cycle_meter_chk.sv
module prbs_cycle_meter_chk #(
    parameter int unsigned WIDTH = 16,
    localparam int unsigned CNT_W = WIDTH + 1
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             step_i,
    input logic             load_i,
    input logic [WIDTH-1:0] state_o,
    input logic [CNT_W-1:0] steps_o,
    input logic             wrap_o
);
    assert_shift_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !load_i) |=> (state_o[WIDTH-2:0] == $past(state_o[WIDTH-1:1])));

    assert_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!step_i && !load_i) |=> ($stable(state_o) && $stable(steps_o) && !wrap_o));

    assert_count_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !load_i) |=> ((steps_o == $past(steps_o) + 1'b1) || (wrap_o && steps_o == '0)));

    assert_load_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (steps_o == '0 && !wrap_o));

    assert_nonzero_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (state_o != '0));

    assert_wrap_clear_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |-> (steps_o == '0));

    assert_wrap_pulse_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |=> !wrap_o);
endmodule

bind prbs_cycle_meter prbs_cycle_meter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .step_i  (step_i),
    .load_i  (load_i),
    .state_o (state_o),
    .steps_o (steps_o),
    .wrap_o  (wrap_o)
);

// File: tb/sim_prbs_cycle_meter.sv
`timescale 1ns/1ps
module sim_prbs_cycle_meter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic        load = 1'b0;
    logic [15:0] seed = 16'h0;
    logic [15:0] state;
    logic [16:0] steps;
    logic        wrap;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    prbs_cycle_meter u0 (
        .clk_i   (clk),
        .rst_i   (rst),
        .step_i  (step),
        .load_i  (load),
        .seed_i  (seed),
        .state_o (state),
        .steps_o (steps),
        .wrap_o  (wrap)
    );

    // Scoreboard queues.
    logic [15:0] q_state[$];
    logic [16:0] q_steps[$];
    logic        q_wrap[$];
    logic        q_adv[$];
    logic        q_clr[$];
    string       q_tag[$];

    // Reference state built from the requirements.
    logic [15:0] m_state = 16'hACE1;
    logic [15:0] m_seed  = 16'hACE1;
    logic [16:0] m_steps = '0;
    logic        m_wrap  = 1'b0;

    task automatic tick(input logic r, input logic s, input logic l,
                        input logic [15:0] sv, input string tag);
        logic nb;
        @(negedge clk);
        rst = r; step = s; load = l; seed = sv;
        m_wrap = 1'b0;
        if (r) begin
            m_state = 16'hACE1; m_seed = 16'hACE1; m_steps = '0;
        end else if (l) begin
            m_state = (sv == 16'h0) ? 16'hACE1 : sv;
            m_seed  = m_state; m_steps = '0;
        end else if (s) begin
            nb = m_state[0] ^ m_state[2] ^ m_state[3] ^ m_state[5];
            m_state = {nb, m_state[15:1]};
            if (m_state == m_seed) begin
                m_wrap = 1'b1; m_steps = '0;
            end else begin
                m_steps = m_steps + 1'b1;
            end
        end
        q_state.push_back(m_state);
        q_steps.push_back(m_steps);
        q_wrap.push_back(m_wrap);
        q_adv.push_back(s && !l && !r);
        q_clr.push_back(l || r);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare after every rising edge, away from it.
    int run_len = 0;
    always @(posedge clk) begin
        #1;
        if (q_state.size() > 0) begin
            logic [15:0] es; logic [16:0] ec; logic ew, adv, clr; string tg;
            es = q_state.pop_front(); ec = q_steps.pop_front();
            ew = q_wrap.pop_front();  adv = q_adv.pop_front();
            clr = q_clr.pop_front();  tg = q_tag.pop_front();
            checks++;
            if (state !== es || steps !== ec || wrap !== ew) begin
                errors++;
                $display("FAIL %s: state=%h steps=%0d wrap=%b expected state=%h steps=%0d wrap=%b",
                         tg, state, steps, wrap, es, ec, ew);
            end
            // R8: period measured purely from the ports.
            if (clr) run_len = 0;
            else if (adv) run_len++;
            if (wrap === 1'b1) begin
                checks++;
                if (run_len != 65535) begin
                    errors++;
                    $display("FAIL R8: period=%0d expected=%0d", run_len, 65535);
                end
                run_len = 0;
            end
        end
    end

    int wraps_seen = 0;
    always @(posedge clk) begin
        #2;
        if (wrap === 1'b1) wraps_seen++;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(1, 0, 0, 16'h0, "R1");
        tick(1, 1, 1, 16'h1234, "R1");
        for (int i = 0; i < 6; i++) tick(0, 1, 0, 16'h0, "R2_R4");
        for (int i = 0; i < 3; i++) tick(0, 0, 0, 16'h0, "R3");
        tick(0, 1, 0, 16'h0, "R2_R4");
        tick(0, 1, 1, 16'h1234, "R5");
        tick(0, 0, 0, 16'h0, "R7_no_wrap_after_load");
        for (int i = 0; i < 4; i++) tick(0, 1, 0, 16'h0, "R2_R4");
        tick(0, 1, 1, 16'h0000, "R6");
        tick(0, 0, 1, 16'h0000, "R6");
        // Full period from the default seed, with a pause inside it.
        for (int i = 0; i < 30000; i++) tick(0, 1, 0, 16'h0, "R7");
        for (int i = 0; i < 3; i++) tick(0, 0, 0, 16'h0, "R3");
        for (int i = 0; i < 35536; i++) tick(0, 1, 0, 16'h0, "R7");
        tick(0, 0, 0, 16'h0, "R7");
        // Full period from a loaded seed.
        tick(0, 1, 1, 16'h0001, "R5");
        for (int i = 0; i < 65536; i++) tick(0, 1, 0, 16'h0, "R7");
        tick(0, 0, 0, 16'h0, "R3");
        repeat (3) @(negedge clk);
        checks++;
        if (wraps_seen != 2) begin
            errors++;
            $display("FAIL R8: wraps=%0d expected=%0d", wraps_seen, 2);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule